// File: doc/BRIEF.md
# ISDN Channel Byte FIFO Pair with Fault Shutdown

This block buffers one ISDN channel in both directions. The transmit lane is filled with bytes from the USB side and drained by the line interface toward the S-bus. The receive lane is filled by the line interface and drained toward USB. Each lane has its own enable command and its own fault detection.

A fault does more than raise a flag. The lane that faults empties itself and switches off. Its fault flag then stays set until software issues that lane's enable command, which restarts the lane empty and clears the flag. The transmit lane also reports its fill level and a ready flag that says at least half of its storage is free. The receive lane reports its fill level. Both lanes report whether they are active. Line coding, HDLC framing and collision retry are handled elsewhere.

Top module: `chfifo_top`

## Requirements
- R1: After reset both lanes are inactive, both levels read 0, every fault flag is 0 and `tx_ready` is 1.
- R2: While a lane is inactive, its write strobe has no effect on its level, and its read strobe returns `*_rvalid` = 0 and raises no flag.
- R3: A lane's enable command makes the lane active with level 0 and clears that lane's fault flags on the next clock. Write and read strobes in the same cycle as the enable are ignored.
- R4: An active lane returns bytes in the order they were written. A read of a non-empty lane shows `*_rvalid` = 1 and the oldest byte on `*_rdata` in the cycle the read strobe is high. The level counts stored bytes from 0 to 16.
- R5: `tx_ready` is 1 exactly when `tx_level` is at most 8, which is half of the 16-byte depth.
- R6: A transmit write while the transmit lane holds 16 bytes sets `tx_ovf_flag`, even if a read comes in the same cycle. On the next clock the lane becomes inactive with level 0.
- R7: A transmit read while the transmit lane is active and empty sets `tx_udr_flag`, even if a write comes in the same cycle. On the next clock the lane becomes inactive with level 0.
- R8: A receive write while the receive lane holds 16 bytes sets `rx_ovf_flag`. On the next clock the lane becomes inactive with level 0.
- R9: A read of an active but empty receive lane returns `rx_rvalid` = 0. It does not change the level, the active state or any flag.
- R10: Fault flags stay set until that lane's enable command. If an enable and a fault condition happen in the same cycle, the enable wins: the lane ends active and empty with its flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en_cmd | input | 1 | Transmit enable command: restarts the lane and clears its flags |
| tx_wr | input | 1 | Transmit write strobe (USB side) |
| tx_wdata | input | 8 | Transmit write byte |
| tx_rd | input | 1 | Transmit read strobe (line side) |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_rvalid | output | 1 | Transmit read delivered a byte this cycle |
| tx_level | output | 5 | Transmit fill level |
| tx_ready | output | 1 | At least half of the transmit storage is free |
| tx_active | output | 1 | Transmit lane is enabled |
| tx_udr_flag | output | 1 | Transmit underrun fault |
| tx_ovf_flag | output | 1 | Transmit overflow fault |
| rx_en_cmd | input | 1 | Receive enable command: restarts the lane and clears its flag |
| rx_wr | input | 1 | Receive write strobe (line side) |
| rx_wdata | input | 8 | Receive write byte |
| rx_rd | input | 1 | Receive read strobe (USB side) |
| rx_rdata | output | 8 | Oldest receive byte |
| rx_rvalid | output | 1 | Receive read delivered a byte this cycle |
| rx_level | output | 5 | Receive fill level |
| rx_active | output | 1 | Receive lane is enabled |
| rx_ovf_flag | output | 1 | Receive overflow fault |

## Verification
A wrong pointer or count shows up at the ports within one cycle. It appears as a wrong byte or a missing `*_rvalid` on the next read, or as a level that is off by one. A wrong level also moves the edge at which `tx_ready` falls. A missed fault shows up one clock after the faulting strobe: the lane is still active, or its level is not zero, or its flag is clear. A flag that is not sticky shows up on any later idle cycle before the enable command. Each check therefore samples the ports one clock after the stimulus, or in the same cycle for the read data.

// File: rtl/chfifo_pkg.sv
package chfifo_pkg;
  localparam int unsigned CH_DEPTH  = 16;
  localparam int unsigned CH_BYTE_W = 8;

  typedef struct packed {
    logic active;
    logic ovf;
    logic udr;
  } lane_stat_t;
endpackage

// File: rtl/chfifo_store.sv
module chfifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/chfifo_lane.sv
module chfifo_lane
  import chfifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned WIDTH     = 8,
  parameter bit          CHECK_UDR = 1'b0,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned LW       = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_cmd,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid,
  output logic [LW-1:0]    level,
  output lane_stat_t       stat
);
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LW-1:0] cnt_q, cnt_n;
  lane_stat_t    stat_q, stat_n;
  logic          full, empty, ops_ok, do_wr, do_rd, ovf_evt, udr_evt;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign ops_ok  = stat_q.active && !en_cmd;
  assign do_wr   = ops_ok && wr && !full;
  assign do_rd   = ops_ok && rd && !empty;
  assign ovf_evt = ops_ok && wr && full;
  assign udr_evt = CHECK_UDR && ops_ok && rd && empty;

  chfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .we    (do_wr),
    .waddr (wptr_q),
    .wdata (wdata),
    .raddr (rptr_q),
    .rdata (rdata)
  );

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    stat_n = stat_q;
    if (en_cmd) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
      stat_n = '{active: 1'b1, ovf: 1'b0, udr: 1'b0};
    end else if (ovf_evt || udr_evt) begin
      wptr_n        = '0;
      rptr_n        = '0;
      cnt_n         = '0;
      stat_n.active = 1'b0;
      stat_n.ovf    = stat_q.ovf | ovf_evt;
      stat_n.udr    = stat_q.udr | udr_evt;
    end else begin
      if (do_wr) wptr_n = wptr_q + 1'b1;
      if (do_rd) rptr_n = rptr_q + 1'b1;
      cnt_n = cnt_q + LW'(do_wr) - LW'(do_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      stat_q <= stat_n;
    end
  end

  assign rvalid = do_rd;
  assign level  = cnt_q;
  assign stat   = stat_q;

  AST_EN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd |=> (stat.active && !stat.ovf && !stat.udr && level == '0)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat.ovf || stat.udr) && !en_cmd) |=> (stat.ovf || stat.udr)); // R10
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat.active && !en_cmd) |=> (!stat.active && level == '0)); // R2
  AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R4
endmodule

// File: rtl/chfifo_top.sv
module chfifo_top
  import chfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = CH_DEPTH,
  parameter int unsigned BYTE_W = CH_BYTE_W,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1,
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_cmd,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_wdata,
  input  logic              tx_rd,
  output logic [BYTE_W-1:0] tx_rdata,
  output logic              tx_rvalid,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_ready,
  output logic              tx_active,
  output logic              tx_udr_flag,
  output logic              tx_ovf_flag,
  input  logic              rx_en_cmd,
  input  logic              rx_wr,
  input  logic [BYTE_W-1:0] rx_wdata,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_rdata,
  output logic              rx_rvalid,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_active,
  output logic              rx_ovf_flag
);
  logic       rst_s1_q, rst_s2_q, rst_n_s;
  lane_stat_t tx_stat, rx_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n_s = rst_s2_q;

  chfifo_lane #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .CHECK_UDR(1'b1)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en_cmd (tx_en_cmd),
    .wr     (tx_wr),
    .wdata  (tx_wdata),
    .rd     (tx_rd),
    .rdata  (tx_rdata),
    .rvalid (tx_rvalid),
    .level  (tx_level),
    .stat   (tx_stat)
  );

  chfifo_lane #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .CHECK_UDR(1'b0)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en_cmd (rx_en_cmd),
    .wr     (rx_wr),
    .wdata  (rx_wdata),
    .rd     (rx_rd),
    .rdata  (rx_rdata),
    .rvalid (rx_rvalid),
    .level  (rx_level),
    .stat   (rx_stat)
  );

  assign tx_active   = tx_stat.active;
  assign tx_udr_flag = tx_stat.udr;
  assign tx_ovf_flag = tx_stat.ovf;
  assign tx_ready    = (tx_level <= LVL_W'(HALF));
  assign rx_active   = rx_stat.active;
  assign rx_ovf_flag = rx_stat.ovf;

  AST_TX_OVF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tx_ovf_flag) |-> (!tx_active && tx_level == '0)); // R6
  AST_TX_UDR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tx_udr_flag) |-> (!tx_active && tx_level == '0)); // R7
  AST_RX_OVF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rx_ovf_flag) |-> (!rx_active && rx_level == '0)); // R8
  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_active && rx_level == '0 && rx_rd && !rx_wr && !rx_en_cmd)
      |=> (rx_active && rx_level == '0 && !rx_ovf_flag)); // R9
endmodule

// File: tb/tb_chfifo_top.sv
module tb_chfifo_top;
  localparam int DEPTH = 16;

  logic       clk, rst_n;
  logic       tx_en_cmd, tx_wr, tx_rd, rx_en_cmd, rx_wr, rx_rd;
  logic [7:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic       tx_rvalid, tx_ready, tx_active, tx_udr_flag, tx_ovf_flag;
  logic       rx_rvalid, rx_active, rx_ovf_flag;
  logic [4:0] tx_level, rx_level;
  int total = 0;
  int bad   = 0;

  chfifo_top dut (
    .clk(clk), .rst_n(rst_n),
    .tx_en_cmd(tx_en_cmd), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd),
    .tx_rdata(tx_rdata), .tx_rvalid(tx_rvalid), .tx_level(tx_level),
    .tx_ready(tx_ready), .tx_active(tx_active), .tx_udr_flag(tx_udr_flag),
    .tx_ovf_flag(tx_ovf_flag),
    .rx_en_cmd(rx_en_cmd), .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_rvalid(rx_rvalid), .rx_level(rx_level),
    .rx_active(rx_active), .rx_ovf_flag(rx_ovf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tx_en_cmd = 0; tx_wr = 0; tx_rd = 0; tx_wdata = 0;
    rx_en_cmd = 0; rx_wr = 0; rx_rd = 0; rx_wdata = 0;
  endtask

  task automatic tx_enable();
    tx_en_cmd = 1; step(); tx_en_cmd = 0;
  endtask

  task automatic rx_enable();
    rx_en_cmd = 1; step(); rx_en_cmd = 0;
  endtask

  task automatic tx_push(input logic [7:0] b);
    tx_wr = 1; tx_wdata = b; step(); tx_wr = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_wr = 1; rx_wdata = b; step(); rx_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_active", tx_active, 0);
    chk("R1 rx_active", rx_active, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 flags", {tx_udr_flag, tx_ovf_flag, rx_ovf_flag}, 0);
    chk("R1 tx_ready", tx_ready, 1);
  endtask

  task automatic t_disabled();
    rx_push(8'h11);
    tx_push(8'h22);
    chk("R2 rx_level off", rx_level, 0);
    chk("R2 tx_level off", tx_level, 0);
    rx_rd = 1; tx_rd = 1; #1;
    chk("R2 rx_rvalid off", rx_rvalid, 0);
    chk("R2 tx_rvalid off", tx_rvalid, 0);
    step(); rx_rd = 0; tx_rd = 0;
    chk("R2 no flag", {tx_udr_flag, tx_ovf_flag, rx_ovf_flag}, 0);
  endtask

  task automatic t_order();
    rx_enable();
    chk("R3 rx active", rx_active, 1);
    for (int i = 0; i < 5; i++) rx_push(8'hA0 + 8'(i));
    chk("R4 rx level 5", rx_level, 5);
    for (int i = 0; i < 5; i++) begin
      rx_rd = 1; #1;
      chk("R4 rx rvalid", rx_rvalid, 1);
      chk("R4 rx order", rx_rdata, 8'hA0 + i);
      step(); rx_rd = 0;
    end
    chk("R4 rx level 0", rx_level, 0);
  endtask

  task automatic t_rx_empty_read();
    rx_rd = 1; #1;
    chk("R9 rvalid empty", rx_rvalid, 0);
    step(); rx_rd = 0;
    chk("R9 still active", rx_active, 1);
    chk("R9 level", rx_level, 0);
    chk("R9 flag", rx_ovf_flag, 0);
  endtask

  task automatic t_ready_and_tx_ovf();
    tx_enable();
    for (int i = 0; i < 8; i++) tx_push(8'(i));
    chk("R5 ready at 8", tx_ready, 1);
    tx_push(8'h08);
    chk("R5 ready at 9", tx_ready, 0);
    for (int i = 9; i < DEPTH; i++) tx_push(8'(i));
    chk("R4 tx level full", tx_level, DEPTH);
    tx_rd = 1; #1;
    chk("R4 tx head", tx_rdata, 0);
    tx_wr = 1; tx_wdata = 8'hFF;
    step(); tx_wr = 0; tx_rd = 0;
    chk("R6 ovf flag", tx_ovf_flag, 1);
    chk("R6 inactive", tx_active, 0);
    chk("R6 level 0", tx_level, 0);
    step();
    chk("R10 ovf sticky", tx_ovf_flag, 1);
    tx_enable();
    chk("R10 enable clears ovf", tx_ovf_flag, 0);
    chk("R3 tx active", tx_active, 1);
  endtask

  task automatic t_tx_udr();
    tx_rd = 1; tx_wr = 1; tx_wdata = 8'h55; #1;
    chk("R7 no data", tx_rvalid, 0);
    step(); tx_rd = 0; tx_wr = 0;
    chk("R7 udr flag", tx_udr_flag, 1);
    chk("R7 inactive", tx_active, 0);
    chk("R7 level 0", tx_level, 0);
    tx_enable();
    chk("R10 enable clears udr", tx_udr_flag, 0);
  endtask

  task automatic t_rx_ovf();
    for (int i = 0; i < DEPTH; i++) rx_push(8'h30 + 8'(i));
    chk("R4 rx full", rx_level, DEPTH);
    rx_push(8'hEE);
    chk("R8 ovf flag", rx_ovf_flag, 1);
    chk("R8 inactive", rx_active, 0);
    chk("R8 level 0", rx_level, 0);
    rx_push(8'h01);
    chk("R10 rx sticky", rx_ovf_flag, 1);
    chk("R2 rx off write", rx_level, 0);
  endtask

  task automatic t_collide();
    for (int i = 0; i < DEPTH; i++) tx_push(8'(i));
    tx_en_cmd = 1; tx_wr = 1; tx_wdata = 8'h77;
    step(); tx_en_cmd = 0; tx_wr = 0;
    chk("R10 collide flag", tx_ovf_flag, 0);
    chk("R10 collide active", tx_active, 1);
    chk("R3 collide level", tx_level, 0);
    rx_en_cmd = 1; rx_wr = 1; rx_wdata = 8'h99;
    step(); rx_en_cmd = 0; rx_wr = 0;
    chk("R3 rx write in enable ignored", rx_level, 0);
    chk("R10 rx enable clears", rx_ovf_flag, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    t_reset();
    t_disabled();
    t_order();
    t_rx_empty_read();
    t_ready_and_tx_ovf();
    t_tx_udr();
    t_rx_ovf();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule